// File: doc/BRIEF.md
# Configurable Serial Sample Receiver

This block is a receive-only serial slave. An external master supplies the bit clock, a sync line and one or two serial data lines. Each data line is a separate sub-channel, and all of them share the clock and the sync. The block detects each sync event and waits a programmable lead delay. It then shifts in a programmable number of bits per line and hands each finished word to that line's own valid/ready output stream. In left/right mode, each word carries the sync level that opened it.

The block runs in the master's clock domain. `clk` runs at twice the bit rate and is phase-locked to the master's bit clock, so every rising `clk` edge lines up with one edge of the bit clock. One `clk` cycle is therefore a half-bit slot. This lets the block place data sampling and sync checks on either bit-clock edge. Each data bit is held for two slots and is sampled in the first of them. Sync and data pass through one input register each, so they stay aligned.

A sync event that arrives too early is a framing error. Too early means before the current word has finished, or inside the guard window that follows it. A word that completes while its stream still holds an unaccepted word is dropped and counted as an overflow. Both flags are sticky until `clr_flags`.

Top module: `drx_rx`

## Requirements
- R1: After a synchronous reset, `out_valid`, `ovf` and `frm_err` are all 0.
- R2: With `cfg_lr_mode`=0 (pulse mode), the sync event is a low-to-high change when `cfg_sync_pol`=0 and a high-to-low change when `cfg_sync_pol`=1. The opposite edge is not an event. Words in this mode carry `out_lr`=0.
- R3: With `cfg_lr_mode`=1 (left/right mode), every change of sync is an event. The word it opens carries `out_lr` equal to the new sync level.
- R4: `cfg_lsb_first`=0 takes the first received bit as bit wl-1 of the word. `cfg_lsb_first`=1 takes it as bit 0.
- R5: `cfg_lead` gives the number of half-bit slots (0 to 4; 5 to 7 act as 4) from the event slot to the slot where the first bit is sampled. Later bits are sampled every second slot.
- R6: `cfg_wlen` sets the word length wl, clamped to 8..32. Bits above wl-1 in `out_data` are 0.
- R7: Each data line produces its own word stream. A line whose `lane_en` bit is 0 produces no words.
- R8: A presented word keeps `out_valid` high and `out_data`/`out_lr` unchanged until `out_ready` is seen high on a clock edge.
- R9: A word that completes while its stream holds a word not yet accepted is discarded, and that line's `ovf` goes to 1. `ovf` stays set until `clr_flags`. When a set and a clear happen together, the set wins.
- R10: A sync event while a word is still being received sets `frm_err`. The partial word is never output, and the event starts a new word.
- R11: `cfg_trail` codes 0 to 4 give a guard of that many half-bit slots, and codes 5 to 7 give 6 slots. The guard is measured from the slot after the last bit's second slot. A sync event inside the guard sets `frm_err` and still starts a new word.
- R12: `frm_err` stays set until `clr_flags`. When a set and a clear happen together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit slot clock, twice the bit rate, locked to the master bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Sync line from the master |
| sd_in | input | NL | Serial data lines, one per sub-channel |
| cfg_lr_mode | input | 1 | 0 pulse mode, 1 left/right mode |
| cfg_lsb_first | input | 1 | 1 selects least significant bit first |
| cfg_sync_pol | input | 1 | Sync polarity for pulse mode |
| cfg_lead | input | 3 | Slots from sync event to first bit |
| cfg_trail | input | 3 | Guard code after the last bit |
| cfg_wlen | input | WLW | Word length in bits |
| lane_en | input | NL | Per-line enable |
| clr_flags | input | 1 | Clears `ovf` and `frm_err` |
| out_ready | input | NL | Per-line sink ready |
| out_valid | output | NL | Per-line word valid |
| out_data | output | NL*DW | Per-line word, line n at bits n*DW upward |
| out_lr | output | NL | Per-line left/right tag |
| ovf | output | NL | Per-line sticky overflow |
| frm_err | output | 1 | Sticky framing error |

## Verification
The assertions check four things on every cycle: the hold of a stalled word, the stickiness of both flags, the silence of a disabled line, and that an early event inside a word raises the framing flag. Other behaviours only show up when the bench drives a whole frame: which edge counts as an event for each polarity, the bit order, the exact slot of the first sample at each lead value, the word-length clamp, the dropped-word choice and the trailing guard window. The bench covers these with a slot-level model that it compares on every clock.

// File: rtl/drx_pkg.sv
package drx_pkg;
  typedef enum logic [1:0] {FS_IDLE, FS_BITS, FS_GUARD} fstate_e;

  // lead delay in half-bit slots, values above 4 clamp to 4
  function automatic logic [2:0] lead_slots(input logic [2:0] code);
    return (code > 3'd4) ? 3'd4 : code;
  endfunction

  // trailing guard in half-bit slots: 0..4 direct, 5..7 mean 6
  function automatic logic [2:0] guard_slots(input logic [2:0] code);
    return (code > 3'd4) ? 3'd6 : code;
  endfunction
endpackage

// File: rtl/drx_sync_det.sv
module drx_sync_det (
  input  logic clk,
  input  logic rst,
  input  logic sync_in,
  input  logic lr_mode,
  input  logic pol,
  output logic ev,
  output logic lvl
);
  logic sync_q, sync_q2;
  logic [1:0] arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 1'b0;
      sync_q2 <= 1'b0;
      arm     <= 2'b00;
    end else begin
      sync_q  <= sync_in;
      sync_q2 <= sync_q;
      arm     <= {arm[0], 1'b1};
    end
  end

  logic rise, fall;
  always_comb begin
    rise = sync_q & ~sync_q2;
    fall = ~sync_q & sync_q2;
    ev   = arm[1] & (lr_mode ? (rise | fall) : (pol ? fall : rise));
    lvl  = sync_q;
  end
endmodule

// File: rtl/drx_frame_ctl.sv
module drx_frame_ctl
  import drx_pkg::*;
#(
  parameter int DW = 32,
  parameter int MIN_WL = 8,
  localparam int WLW = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ev,
  input  logic           lvl,
  input  logic           lr_mode,
  input  logic [2:0]     lead,
  input  logic [2:0]     trail,
  input  logic [WLW-1:0] wlen,
  input  logic           clr,
  output logic           stb,
  output logic           done,
  output logic [WLW-1:0] wl,
  output logic           tag,
  output logic           frm_err
);
  fstate_e        st;
  logic [3:0]     cnt;
  logic [WLW-1:0] bitn;
  logic [2:0]     lead_h, guard_h;
  logic           early;

  always_comb begin
    lead_h  = lead_slots(lead);
    guard_h = guard_slots(trail);
    if (wlen < WLW'(MIN_WL))  wl = WLW'(MIN_WL);
    else if (wlen > WLW'(DW)) wl = WLW'(DW);
    else                      wl = wlen;
    stb   = (ev && lead_h == 3'd0) || (!ev && st == FS_BITS && cnt == 4'd1);
    done  = !ev && st == FS_BITS && cnt == 4'd1 && bitn == wl - 1'b1;
    early = ev && st != FS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_IDLE;
      cnt     <= 4'd0;
      bitn    <= '0;
      tag     <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      if (ev) begin
        st  <= FS_BITS;
        tag <= lr_mode & lvl;
        if (lead_h == 3'd0) begin
          cnt  <= 4'd2;
          bitn <= WLW'(1);
        end else begin
          cnt  <= {1'b0, lead_h};
          bitn <= '0;
        end
      end else if (st == FS_BITS) begin
        if (cnt == 4'd1) begin
          if (done) begin
            st  <= FS_GUARD;
            cnt <= {1'b0, guard_h} + 4'd1;
          end else begin
            cnt  <= 4'd2;
            bitn <= bitn + 1'b1;
          end
        end else begin
          cnt <= cnt - 4'd1;
        end
      end else if (st == FS_GUARD) begin
        if (cnt == 4'd1) st <= FS_IDLE;
        else             cnt <= cnt - 4'd1;
      end
      if (early)    frm_err <= 1'b1;
      else if (clr) frm_err <= 1'b0;
    end
  end

  AST_EARLY_SYNC_FLAGS: assert property (@(posedge clk) disable iff (rst)
    early |=> frm_err); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (frm_err && !clr) |=> frm_err); // R12
endmodule

// File: rtl/drx_lane.sv
module drx_lane #(
  parameter int DW = 32,
  localparam int WLW = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stb,
  input  logic           done,
  input  logic           bit_in,
  input  logic           lsb_first,
  input  logic [WLW-1:0] wl,
  input  logic           tag,
  input  logic           en,
  input  logic           clr,
  input  logic           ready,
  output logic           valid,
  output logic [DW-1:0]  data,
  output logic           lr,
  output logic           ovf
);
  logic [DW-1:0] sh, sh_nx, word;

  always_comb begin
    sh_nx = lsb_first ? {bit_in, sh[DW-1:1]} : {sh[DW-2:0], bit_in};
    word  = lsb_first ? (sh_nx >> (WLW'(DW) - wl))
                      : (sh_nx & ({DW{1'b1}} >> (WLW'(DW) - wl)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      valid <= 1'b0;
      data  <= '0;
      lr    <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      if (stb) sh <= sh_nx;
      if (done && en) begin
        if (valid && !ready) begin
          ovf <= 1'b1;
        end else begin
          valid <= 1'b1;
          data  <= word;
          lr    <= tag;
        end
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
      if (clr && !(done && en && valid && !ready)) ovf <= 1'b0;
    end
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data) && $stable(lr))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr) |=> ovf); // R9
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!en && !valid) |=> !valid); // R7
endmodule

// File: rtl/drx_rx.sv
module drx_rx #(
  parameter int DW = 32,
  parameter int NL = 2,
  parameter int MIN_WL = 8,
  localparam int WLW = $clog2(DW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_in,
  input  logic [NL-1:0]     sd_in,
  input  logic              cfg_lr_mode,
  input  logic              cfg_lsb_first,
  input  logic              cfg_sync_pol,
  input  logic [2:0]        cfg_lead,
  input  logic [2:0]        cfg_trail,
  input  logic [WLW-1:0]    cfg_wlen,
  input  logic [NL-1:0]     lane_en,
  input  logic              clr_flags,
  input  logic [NL-1:0]     out_ready,
  output logic [NL-1:0]     out_valid,
  output logic [NL*DW-1:0]  out_data,
  output logic [NL-1:0]     out_lr,
  output logic [NL-1:0]     ovf,
  output logic              frm_err
);
  logic [NL-1:0]  sd_q;
  logic           ev, lvl, stb, done, tag;
  logic [WLW-1:0] wl;

  always_ff @(posedge clk) begin
    if (rst) sd_q <= '0;
    else     sd_q <= sd_in;
  end

  drx_sync_det u_sync (
    .clk(clk), .rst(rst), .sync_in(sync_in), .lr_mode(cfg_lr_mode),
    .pol(cfg_sync_pol), .ev(ev), .lvl(lvl)
  );

  drx_frame_ctl #(.DW(DW), .MIN_WL(MIN_WL)) u_ctl (
    .clk(clk), .rst(rst), .ev(ev), .lvl(lvl), .lr_mode(cfg_lr_mode),
    .lead(cfg_lead), .trail(cfg_trail), .wlen(cfg_wlen), .clr(clr_flags),
    .stb(stb), .done(done), .wl(wl), .tag(tag), .frm_err(frm_err)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lane
    drx_lane #(.DW(DW)) u_lane (
      .clk(clk), .rst(rst), .stb(stb), .done(done), .bit_in(sd_q[l]),
      .lsb_first(cfg_lsb_first), .wl(wl), .tag(tag), .en(lane_en[l]),
      .clr(clr_flags), .ready(out_ready[l]), .valid(out_valid[l]),
      .data(out_data[l*DW +: DW]), .lr(out_lr[l]), .ovf(ovf[l])
    );
  end
endmodule

// File: tb/tb_drx_rx.sv
module tb_drx_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_in = 1'b0;
  logic [1:0] sd_in = 2'b00;
  logic mode = 1'b0, lsb = 1'b0, pol = 1'b0, clr = 1'b0;
  logic [2:0] lead = 3'd2, trail = 3'd0;
  logic [5:0] wlen = 6'd16;
  logic [1:0] en = 2'b11, rdy = 2'b11;
  logic [1:0] out_valid, out_lr, ovf;
  logic [63:0] out_data;
  logic frm_err;

  // requested values, applied at the next slot
  logic rst_r = 1'b1, mode_r = 1'b0, lsb_r = 1'b0, pol_r = 1'b0, clr_r = 1'b0;
  logic [2:0] lead_r = 3'd2, trail_r = 3'd0;
  logic [5:0] wlen_r = 6'd16;
  logic [1:0] en_r = 2'b11, rdy_r = 2'b11;

  drx_rx dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .sd_in(sd_in),
    .cfg_lr_mode(mode), .cfg_lsb_first(lsb), .cfg_sync_pol(pol),
    .cfg_lead(lead), .cfg_trail(trail), .cfg_wlen(wlen), .lane_en(en),
    .clr_flags(clr), .out_ready(rdy), .out_valid(out_valid),
    .out_data(out_data), .out_lr(out_lr), .ovf(ovf), .frm_err(frm_err)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  int pidx = -1;
  int err_until = -1;
  logic sync_lvl = 1'b0;
  string cur_req = "R1";
  bit [32:0] pend0 [int];
  bit [32:0] pend1 [int];
  bit perr [int];
  logic [1:0] e_v, e_lr, e_ovf;
  logic [31:0] e_d [2];
  logic e_err;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at slot %0d", req, what, act, exp, pidx);
    end
  endtask

  function automatic int guard_of(input int code);
    return (code > 4) ? 6 : code;
  endfunction

  task automatic step(input logic s, input logic [1:0] d);
    @(negedge clk);
    pidx++;
    if (rst) begin
      e_v = 0; e_lr = 0; e_ovf = 0; e_err = 0; e_d[0] = 0; e_d[1] = 0;
    end else begin
      for (int l = 0; l < 2; l++) begin
        bit has; bit [32:0] pw; bit setovf;
        has = (l == 0) ? pend0.exists(pidx) : pend1.exists(pidx);
        setovf = 0;
        if (has) begin
          pw = (l == 0) ? pend0[pidx] : pend1[pidx];
          if (l == 0) pend0.delete(pidx); else pend1.delete(pidx);
          if (e_v[l] && !rdy[l]) begin
            e_ovf[l] = 1; setovf = 1;
          end else begin
            e_v[l] = 1; e_d[l] = pw[31:0]; e_lr[l] = pw[32];
          end
        end else if (e_v[l] && rdy[l]) e_v[l] = 0;
        if (clr && !setovf) e_ovf[l] = 0;
      end
      if (perr.exists(pidx)) begin
        e_err = 1; perr.delete(pidx);
      end else if (clr) e_err = 0;
    end
    for (int l = 0; l < 2; l++) begin
      chk(out_valid[l] == e_v[l], cur_req, "out_valid", out_valid[l], e_v[l]);
      chk(ovf[l] == e_ovf[l], cur_req, "ovf", ovf[l], e_ovf[l]);
      if (e_v[l]) begin
        chk(out_data[l*32 +: 32] == e_d[l], cur_req, "out_data", out_data[l*32 +: 32], e_d[l]);
        chk(out_lr[l] == e_lr[l], cur_req, "out_lr", out_lr[l], e_lr[l]);
      end
    end
    chk(frm_err == e_err, cur_req, "frm_err", frm_err, e_err);
    rst = rst_r; mode = mode_r; lsb = lsb_r; pol = pol_r; clr = clr_r;
    lead = lead_r; trail = trail_r; wlen = wlen_r; en = en_r; rdy = rdy_r;
    sync_in = s; sd_in = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(sync_lvl, 2'b00);
  endtask

  task automatic send_word(input logic [31:0] w0, input logic [31:0] w1,
                           input int nbits, input int gap);
    int e, wl, ld, nslots, last;
    logic lv;
    logic [31:0] m;
    e  = pidx + 2;
    wl = int'(wlen);
    ld = int'(lead);
    m  = (wl == 32) ? 32'hFFFF_FFFF : ((32'h1 << wl) - 1);
    if (mode) begin
      sync_lvl = ~sync_lvl; lv = sync_lvl;
    end else lv = 1'b0;
    if (e <= err_until) perr[e + 1] = 1;
    if (nbits == wl) begin
      last = e + ld + 2 * (wl - 1);
      if (en[0]) pend0[last + 1] = {lv, w0 & m};
      if (en[1]) pend1[last + 1] = {lv, w1 & m};
      err_until = last + 1 + guard_of(int'(trail));
    end else err_until = e + ld + 2 * wl;
    nslots = ld + 2 * nbits + gap;
    for (int j = 0; j < nslots; j++) begin
      logic s; logic [1:0] d; int i, idx;
      s = mode ? lv : ((j < 2) ? ~pol : pol);
      d = 2'b00;
      if (j >= ld && (j - ld) / 2 < nbits) begin
        i = (j - ld) / 2;
        idx = lsb ? i : wl - 1 - i;
        d = {w1[idx], w0[idx]};
      end
      step(s, d);
    end
    if (!mode) sync_lvl = pol;
  endtask

  task automatic clear_flags();
    clr_r = 1; idle(1); clr_r = 0; idle(2);
  endtask

  bit finished = 0;

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_r = 0;
    idle(6);
    // R1 explicit reset state
    chk(out_valid == 2'b00, "R1", "out_valid after reset", out_valid, 0);
    chk(ovf == 2'b00, "R1", "ovf after reset", ovf, 0);
    chk(frm_err == 1'b0, "R1", "frm_err after reset", frm_err, 0);

    // R2 R4 R7 pulse mode, rising event, msb first, two lanes
    cur_req = "R2";
    send_word(32'h0000_A5C3, 32'h0000_1E7F, 16, 2);
    send_word(32'h0000_0F0F, 32'h0000_8001, 16, 4);
    idle(8);

    // R2 falling event with polarity set, R4 lsb first
    cur_req = "R4";
    pol_r = 1; lsb_r = 1; sync_lvl = 1'b1; idle(6);
    send_word(32'h0000_C001, 32'h0000_3AB2, 16, 3);
    send_word(32'h0000_1234, 32'h0000_FEDC, 16, 0);
    idle(8);
    lsb_r = 0; idle(2);

    // R5 lead sweep, R6 word length 8
    cur_req = "R5";
    wlen_r = 6'd8; idle(2);
    for (int k = 0; k <= 4; k++) begin
      lead_r = 3'(k); idle(3);
      send_word(32'h96 ^ 32'(k), 32'h3C + 32'(k), 8, 3);
    end
    lead_r = 3'd2; idle(4);

    // R6 long and odd lengths, out-of-range clamp to 32
    cur_req = "R6";
    wlen_r = 6'd32; idle(3);
    send_word(32'hDEAD_BEEF, 32'h8765_4321, 32, 2);
    wlen_r = 6'd12; idle(3);
    send_word(32'h0000_0ABC, 32'h0000_0555, 12, 2);
    wlen_r = 6'd40; idle(3);
    wlen = 6'd32; // model reads the clamped length
    send_word(32'hF00D_1234, 32'h0BAD_CAFE, 32, 2);
    wlen_r = 6'd16; idle(4);

    // R7 lane 1 disabled
    cur_req = "R7";
    en_r = 2'b01; idle(3);
    send_word(32'h0000_7777, 32'h0000_9999, 16, 3);
    idle(6);
    en_r = 2'b11; idle(3);

    // R3 left/right mode, back to back words
    cur_req = "R3";
    mode_r = 1; idle(4);
    send_word(32'h0000_1111, 32'h0000_2222, 16, 0);
    send_word(32'h0000_3333, 32'h0000_4444, 16, 0);
    send_word(32'h0000_5A5A, 32'h0000_A5A5, 16, 0);
    idle(8);

    // R8 R9 stall lane 0, overflow, then drain and clear
    cur_req = "R9";
    rdy_r = 2'b10; idle(2);
    send_word(32'h0000_ABCD, 32'h0000_0101, 16, 2);
    send_word(32'h0000_EEEE, 32'h0000_0202, 16, 2);
    cur_req = "R8";
    idle(6);
    rdy_r = 2'b11; idle(3);
    cur_req = "R9";
    clear_flags();

    // R10 abort by early sync, R12 sticky until clear
    cur_req = "R10";
    mode_r = 0; pol_r = 0; sync_lvl = 1'b0; idle(6);
    send_word(32'h0000_6666, 32'h0000_7777, 5, 0);
    send_word(32'h0000_4321, 32'h0000_8765, 16, 3);
    cur_req = "R12";
    idle(10);
    clear_flags();

    // R11 guard of 6 slots: too early then just in time
    cur_req = "R11";
    trail_r = 3'd5; idle(3);
    send_word(32'h0000_1357, 32'h0000_2468, 16, 3);
    send_word(32'h0000_9BDF, 32'h0000_ACE0, 16, 6);
    idle(4);
    clear_flags();
    send_word(32'h0000_0F1E, 32'h0000_2D3C, 16, 6);
    send_word(32'h0000_4B5A, 32'h0000_6978, 16, 6);
    trail_r = 3'd2; idle(3);
    send_word(32'h0000_8796, 32'h0000_A5B4, 16, 1);
    send_word(32'h0000_C3D2, 32'h0000_E1F0, 16, 4);
    idle(10);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule